// File: doc/BRIEF.md
# Split-Read Timestamp Counter

This block is a free-running cycle counter that is twice as wide as one half-word. Software reaches it through a simple register bus that reads and writes single words. A control register starts and stops counting. The counter's lower and upper halves each have their own read address. Software cannot fetch both halves in one access, so a carry out of the lower half can land between the two reads. When that happens, the pair that software assembles is wrong.

The block does not freeze a snapshot. Instead it watches each read sequence and reports on it. Software reads the low half, then the high half, then the control register. The top bit of that control read says whether the pair it just took is coherent. When the bit is 0, software repeats the three reads. Each control read closes the sequence and starts tracking afresh.

Read data is combinational from the current state in the cycle that the read strobe is high. Side effects of an access take place at the closing clock edge.

Top module: `tsc_split_counter`

## Requirements
- R1: After reset, the counter is zero and counting is disabled. The control register, the low half and the high half all read 0.
- R2: A write to the control address (0x103) with write-data bit 0 equal to 1 enables counting. From the edge after the write onwards, the counter rises by exactly one per clock.
- R3: A control write with write-data bit 0 equal to 0 stops counting. The counter then holds its value until it is enabled again.
- R4: The low half reads at address 0x104 and the high half at 0x105, each zero-extended to the bus width. A read of any other address returns 0.
- R5: A control read returns the enable in bit 0 and the pair status in bit 31. All other bits read 0.
- R6: The full counter wraps from all ones to zero.
- R7: Status bit 31 reads 1 only after the following sequence since the last control read: a low read, then a high read, with no carry from the low half into the high half in between.
- R8: Status reads 0 after a low-to-high carry at any edge from the low read's own edge up to, but not including, the high read's edge. The low read's own edge counts when the low half was all ones during that read.
- R9: A carry at the edge of the high read itself does not spoil the pair.
- R10: Every control read restarts tracking. A second control read, or a high read with no low read before it, yields status 0.
- R11: Writes to the low or high address have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the cycle bus_rd is high |

## Verification
The hardest situation to reach is a carry that falls exactly on the low read's edge, or exactly on the high read's edge. The two cases lie one cycle apart, and they must give opposite status values. The bench makes the low half narrow, so carries occur every few dozen cycles. It steps idle cycles until its own model of the counter sits a chosen distance below the carry, and only then issues the reads. Random mixed traffic afterwards lands on many other carry offsets.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_PAIR = 2'd2
   } tsc_phase_e;
endpackage

// File: rtl/tsc_counter.sv
`timescale 1ns/1ps
module tsc_counter #(
   parameter int HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   output logic [HALF_W-1:0] cnt_lo,
   output logic [HALF_W-1:0] cnt_hi,
   output logic              lo_carry
);
   localparam logic [HALF_W-1:0] HALF_ONES = '1;

   assign lo_carry = count_en && (cnt_lo == HALF_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else if (count_en) begin
         cnt_lo <= cnt_lo + 1'b1;
         if (cnt_lo == HALF_ONES) cnt_hi <= cnt_hi + 1'b1;
      end
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count_en |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1));
   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> $stable({cnt_hi, cnt_lo}));
   // R6
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && (&{cnt_hi, cnt_lo})) |=> ({cnt_hi, cnt_lo} == '0));
endmodule

// File: rtl/tsc_pair_track.sv
`timescale 1ns/1ps
module tsc_pair_track
   import tsc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_lo,
   input  logic rd_hi,
   input  logic rd_ctrl,
   input  logic lo_carry,
   output logic pair_ok
);
   tsc_phase_e phase;
   logic       clean;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         clean <= 1'b0;
      end else if (rd_ctrl) begin
         phase <= PH_IDLE;
         clean <= 1'b0;
      end else if (rd_lo) begin
         phase <= PH_LOW;
         clean <= !lo_carry;
      end else if (rd_hi) begin
         if (phase == PH_LOW) phase <= PH_PAIR;
      end else if (phase == PH_LOW && lo_carry) begin
         clean <= 1'b0;
      end
   end

   assign pair_ok = (phase == PH_PAIR) && clean;

   // R8
   carry_spoil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_carry && !rd_ctrl && !rd_hi && (rd_lo || phase == PH_LOW)) |=> !clean);
   // R10
   ctrl_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctrl |=> (phase == PH_IDLE && !pair_ok));
   // R9
   hi_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi && !rd_lo && !rd_ctrl && phase == PH_LOW) |=> (phase == PH_PAIR && clean == $past(clean)));
endmodule

// File: rtl/tsc_regif.sv
`timescale 1ns/1ps
module tsc_regif #(
   parameter int ADDR_W    = 12,
   parameter int BUS_W     = 32,
   parameter int HALF_W    = 32,
   parameter int CTRL_ADDR = 'h103,
   parameter int LO_ADDR   = 'h104,
   parameter int HI_ADDR   = 'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              wr_en_bit,
   input  logic [HALF_W-1:0] cnt_lo,
   input  logic [HALF_W-1:0] cnt_hi,
   input  logic              pair_ok,
   output logic              count_en,
   output logic              rd_lo,
   output logic              rd_hi,
   output logic              rd_ctrl,
   output logic [BUS_W-1:0]  rdata
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HI_ADDR);
   localparam int                STAT_B = BUS_W - 1;

   logic [BUS_W-1:0] lo_ext, hi_ext, ctrl_word;

   generate
      if (HALF_W == BUS_W) begin : g_full
         assign lo_ext = cnt_lo;
         assign hi_ext = cnt_hi;
      end else begin : g_pad
         assign lo_ext = {{(BUS_W-HALF_W){1'b0}}, cnt_lo};
         assign hi_ext = {{(BUS_W-HALF_W){1'b0}}, cnt_hi};
      end
   endgenerate

   assign rd_ctrl = rd && (addr == A_CTRL);
   assign rd_lo   = rd && (addr == A_LO);
   assign rd_hi   = rd && (addr == A_HI);

   always_comb begin
      ctrl_word         = '0;
      ctrl_word[0]      = count_en;
      ctrl_word[STAT_B] = pair_ok;
   end

   always_comb begin
      rdata = '0;
      if (rd_ctrl)    rdata = ctrl_word;
      else if (rd_lo) rdata = lo_ext;
      else if (rd_hi) rdata = hi_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      count_en <= 1'b0;
      else if (wr && addr == A_CTRL)   count_en <= wr_en_bit;
   end

   // R2
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == A_CTRL) |=> (count_en == $past(wr_en_bit)));
   // R3
   en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && addr == A_CTRL) |=> $stable(count_en));
endmodule

// File: rtl/tsc_split_counter.sv
`timescale 1ns/1ps
module tsc_split_counter #(
   parameter int ADDR_W    = 12,
   parameter int BUS_W     = 32,
   parameter int HALF_W    = 32,
   parameter int CTRL_ADDR = 'h103,
   parameter int LO_ADDR   = 'h104,
   parameter int HI_ADDR   = 'h105
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata
);
   generate
      if (HALF_W < 1 || HALF_W > BUS_W) begin : g_bad_half
         $error("HALF_W must lie between 1 and BUS_W");
      end
      if (BUS_W < 2) begin : g_bad_bus
         $error("BUS_W must be at least 2");
      end
      if (CTRL_ADDR == LO_ADDR || CTRL_ADDR == HI_ADDR || LO_ADDR == HI_ADDR) begin : g_bad_map
         $error("register addresses must differ");
      end
   endgenerate

   logic [HALF_W-1:0] cnt_lo, cnt_hi;
   logic              lo_carry, count_en, pair_ok;
   logic              rd_lo, rd_hi, rd_ctrl;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[BUS_W-1:1];

   tsc_regif #(
      .ADDR_W(ADDR_W), .BUS_W(BUS_W), .HALF_W(HALF_W),
      .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
   ) u_regif (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .wr_en_bit(bus_wdata[0]), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
      .pair_ok(pair_ok), .count_en(count_en), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .rd_ctrl(rd_ctrl), .rdata(bus_rdata)
   );

   tsc_counter #(.HALF_W(HALF_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .count_en(count_en),
      .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .lo_carry(lo_carry)
   );

   tsc_pair_track u_track (
      .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_hi(rd_hi),
      .rd_ctrl(rd_ctrl), .lo_carry(lo_carry), .pair_ok(pair_ok)
   );
endmodule

// File: tb/tsc_split_counter_bench.sv
`timescale 1ns/1ps
module tsc_split_counter_bench;
   localparam int ADDR_W = 12;
   localparam int BUS_W  = 32;
   localparam int HALF_W = 6;
   localparam logic [HALF_W-1:0] HMAX = '1;
   localparam logic [ADDR_W-1:0] A_CTRL = 12'h103;
   localparam logic [ADDR_W-1:0] A_LO   = 12'h104;
   localparam logic [ADDR_W-1:0] A_HI   = 12'h105;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0;
   logic              bus_wr = 1'b0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // model of the requirements
   logic [HALF_W-1:0] m_lo = '0, m_hi = '0;
   logic              m_en = 1'b0;
   int                m_ph = 0;
   logic              m_ok = 1'b0;
   logic [BUS_W-1:0]  last_rd;

   always #2 clk = ~clk;

   tsc_split_counter #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .HALF_W(HALF_W)) u_tsc_split_counter (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic logic [BUS_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
      logic [BUS_W-1:0] v = '0;
      if (a == A_CTRL) begin
         v[0] = m_en;
         v[BUS_W-1] = (m_ph == 2) && m_ok;
      end else if (a == A_LO) v[HALF_W-1:0] = m_lo;
      else if (a == A_HI)     v[HALF_W-1:0] = m_hi;
      return v;
   endfunction

   task automatic check(input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic op(input bit rd, input bit wr, input logic [ADDR_W-1:0] a,
                     input logic [BUS_W-1:0] wd, input string req);
      bit carry;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      #1;
      if (rd) begin
         last_rd = bus_rdata;
         check(bus_rdata, exp_read(a), req);
      end
      @(posedge clk);
      carry = m_en && (m_lo == HMAX);
      if (rd && a == A_CTRL) begin m_ph = 0; m_ok = 1'b0; end
      else if (rd && a == A_LO) begin m_ph = 1; m_ok = !carry; end
      else if (rd && a == A_HI) begin if (m_ph == 1) m_ph = 2; end
      else if (m_ph == 1 && carry) m_ok = 1'b0;
      if (m_en) begin
         if (carry) m_hi = m_hi + 1'b1;
         m_lo = m_lo + 1'b1;
      end
      if (wr && a == A_CTRL) m_en = wd[0];
   endtask

   task automatic idle();
      op(1'b0, 1'b0, '0, '0, "");
   endtask

   task automatic wait_lo(input logic [HALF_W-1:0] v);
      while (m_lo != v) idle();
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      op(1, 0, A_CTRL, '0, "R1");
      check(last_rd, 32'h0, "R1");
      op(1, 0, A_LO, '0, "R1");
      op(1, 0, A_HI, '0, "R1");
      repeat (4) idle();
      op(1, 0, A_LO, '0, "R1");
      check(last_rd, 32'h0, "R1");
      // R2 enable and count
      op(0, 1, A_CTRL, 32'h1, "R2");
      repeat (3) idle();
      op(1, 0, A_LO, '0, "R2");
      check(last_rd, 32'd3, "R2");
      // R11 writes to counter halves ignored
      op(0, 1, A_LO, 32'h2A, "R11");
      op(0, 1, A_HI, 32'h15, "R11");
      op(1, 0, A_LO, '0, "R11");
      op(1, 0, A_HI, '0, "R11");
      // R4 unmapped address
      op(1, 0, 12'h100, '0, "R4");
      op(1, 0, 12'h106, '0, "R4");
      // R7 clean pair
      wait_lo(6'd2);
      op(1, 0, A_LO, '0, "R7");
      op(1, 0, A_HI, '0, "R7");
      op(1, 0, A_CTRL, '0, "R7");
      check(last_rd, 32'h8000_0001, "R7");
      // R8 carry on the low read's own edge
      wait_lo(HMAX);
      op(1, 0, A_LO, '0, "R8");
      op(1, 0, A_HI, '0, "R8");
      op(1, 0, A_CTRL, '0, "R8");
      check(last_rd, 32'h0000_0001, "R8");
      // R8 carry during a gap
      wait_lo(HMAX - 6'd3);
      op(1, 0, A_LO, '0, "R8");
      repeat (3) idle();
      op(1, 0, A_HI, '0, "R8");
      op(1, 0, A_CTRL, '0, "R8");
      check(last_rd, 32'h0000_0001, "R8");
      // R9 carry on the high read's edge
      wait_lo(HMAX - 6'd1);
      op(1, 0, A_LO, '0, "R9");
      op(1, 0, A_HI, '0, "R9");
      op(1, 0, A_CTRL, '0, "R9");
      check(last_rd, 32'h8000_0001, "R9");
      // R10 re-arm
      op(1, 0, A_CTRL, '0, "R10");
      check(last_rd, 32'h0000_0001, "R10");
      op(1, 0, A_HI, '0, "R10");
      op(1, 0, A_CTRL, '0, "R10");
      check(last_rd, 32'h0000_0001, "R10");
      // R3 stop holds the value, R5 control format
      op(0, 1, A_CTRL, 32'hFFFF_FFFE, "R3");
      op(1, 0, A_LO, '0, "R3");
      repeat (5) idle();
      op(1, 0, A_LO, '0, "R3");
      op(1, 0, A_CTRL, '0, "R5");
      check(last_rd, 32'h0, "R5");
      // R6 full wrap
      op(0, 1, A_CTRL, 32'h1, "R6");
      while (!(m_lo == HMAX && m_hi == HMAX)) idle();
      op(1, 0, A_LO, '0, "R6");
      op(1, 0, A_HI, '0, "R6");
      check(last_rd, 32'h0, "R6");
      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         int k = $urandom_range(0, 9);
         case (k)
            0, 1:    idle();
            2, 3:    op(1, 0, A_LO, '0, "R2");
            4, 5:    op(1, 0, A_HI, '0, "R4");
            6:       op(1, 0, A_CTRL, '0, "R7");
            7:       op(0, 1, A_CTRL, {$urandom, 1'b0} | ($urandom_range(0, 7) != 0), "R3");
            8:       op(0, 1, ($urandom_range(0, 1) != 0) ? A_LO : A_HI, $urandom, "R11");
            default: op(1, 0, 12'(32'h100 + $urandom_range(0, 7)), '0, "R4");
         endcase
      end
      bus_rd = 1'b0; bus_wr = 1'b0;
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule